// File: doc/BRIEF.md
# Five-Source Prioritized Interrupt Controller

This block gathers interrupt requests from five sources into a pending-flag register and keeps a separate enable mask. Both registers sit on a byte-wide memory-mapped bus that a CPU reads and writes. A master enable bit is not memory mapped. Two strobes from the CPU's instruction decoder control it: one enables interrupts, the other disables them.

A decision is taken whenever three things hold together: the master enable is set, no earlier service request is still waiting for acknowledgement, and some source is both pending and enabled. On that decision the block does four things:
- it picks the lowest-numbered such source;
- it clears that source's pending bit;
- it drops the master enable;
- one cycle later it pulses a service request with the source's vector address.

The CPU performs the stack push and the jump. It then acknowledges, and only after that acknowledgement can the block take another decision.

Top module: `irq_ctrl`

## Requirements
- R1: The enable mask is at bus address 0xFFFF and the pending flags are at 0xFF0F. Each register stores only data bits [4:0]. Bits [7:5] of a read are always zero. A read of any other address returns zero.
- R2: The vector presented for source n is 0x0040 + 8·n (0x40, 0x48, 0x50, 0x58, 0x60 for n = 0..4).
- R3: No service request is made unless the master enable is set and the AND of the flags and the mask is non-zero.
- R4: A decision clears the master enable and the serviced source's flag bit. Every other flag bit keeps its value.
- R5: When several enabled sources are pending, bit 0 is served first and bit 4 last. Exactly one source is served per decision.
- R6: A pulse on `src_set[n]` sets flag bit n on the next edge (bit 0 is the vertical-blank source, bit 4 the button source). When it meets a service clear or a bus write of the same bit, the set wins.
- R7: `ei_strobe` sets the master enable and `di_strobe` clears it. If both arrive in the same cycle, the clear wins.
- R8: `svc_req` is high for exactly one cycle, in the cycle after the decision edge, and `svc_vec` holds the vector from then on. No further decision is made until `svc_ack` has been seen.
- R9: A bus write to the flag register loads its low five bits directly, so software can both raise and clear requests.
- R10: After reset, both registers read zero, the master enable is clear, and `svc_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Bus address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| src_set | input | 5 | Per-source request set strobes |
| ei_strobe | input | 1 | Enable-interrupts instruction strobe |
| di_strobe | input | 1 | Disable-interrupts instruction strobe |
| svc_ack | input | 1 | CPU acknowledgement of the service request |
| svc_req | output | 1 | One-cycle service request pulse |
| svc_vec | output | 16 | Vector address of the serviced source |

## Verification
The bench builds the block with its default parameters: five sources, an 8-bit data path, vector base 0x40 and stride 8. At that size the whole space of 32 flag values against 32 mask values can be swept. For each pair, the bench computes the winning source, its vector and the remaining flags arithmetically. Directed sequences then cover the cases the sweep does not reach: a set strobe colliding with a service clear, enable and disable strobes arriving together, and a decision held back while an acknowledgement is outstanding.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;

  // offset of a source's vector from the vector base
  function automatic logic [31:0] vec_offset(input int unsigned stride,
                                             input int unsigned idx);
    return 32'(stride * idx);
  endfunction

  // next value of one pending bit: bus load, then service clear, then set
  function automatic logic flag_next(input logic cur, input logic wr_en,
                                     input logic wr_bit, input logic clr,
                                     input logic set);
    logic base;
    base = wr_en ? wr_bit : cur;
    return (base & ~clr) | set;
  endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'hFFFF,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'hFF0F
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output reg_sel_e          sel,
  output logic              wr_flag,
  output logic              wr_mask
);

  always_comb begin
    if (addr == FLAG_ADDR)      sel = SEL_FLAG;
    else if (addr == MASK_ADDR) sel = SEL_MASK;
    else                        sel = SEL_NONE;
  end

  assign wr_flag = wr && (sel == SEL_FLAG);
  assign wr_mask = wr && (sel == SEL_MASK);

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
#(
  parameter int unsigned SRC_N = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SRC_N-1:0] wr_data,
  input  logic [SRC_N-1:0] set_in,
  input  logic [SRC_N-1:0] clr_in,
  output logic [SRC_N-1:0] flags
);

  logic [SRC_N-1:0] flags_d;

  for (genvar i = 0; i < SRC_N; i++) begin : g_bit
    assign flags_d[i] = flag_next(flags[i], wr_en, wr_data[i], clr_in[i], set_in[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned SRC_N = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic [SRC_N-1:0] pend,
  output logic [SRC_N-1:0] grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  for (genvar i = 0; i < SRC_N; i++) begin : g_grant
    localparam logic [SRC_N-1:0] LOWER = (SRC_N'(1) << i) - SRC_N'(1);
    assign grant[i] = pend[i] & ~|(pend & LOWER);
  end

  assign any = |pend;

  always_comb begin
    idx = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (grant[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned SRC_N = 5,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'hFFFF,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'hFF0F,
  parameter int unsigned VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 'h0040,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SRC_N-1:0]  src_set,
  input  logic              ei_strobe,
  input  logic              di_strobe,
  input  logic              svc_ack,
  output logic              svc_req,
  output logic [VEC_W-1:0]  svc_vec
);

  localparam int unsigned IDX_W = (SRC_N > 1) ? $clog2(SRC_N) : 1;

  reg_sel_e         sel;
  logic             wr_flag, wr_mask;
  logic [SRC_N-1:0] flag_q, mask_q, pend, grant, svc_clr;
  logic [IDX_W-1:0] win_idx;
  logic             win_any;
  logic             ime_q, busy_q, decide;
  logic [VEC_W-1:0] vec_d;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata;

  irq_bus_decode #(
    .ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR), .FLAG_ADDR(FLAG_ADDR)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .sel(sel), .wr_flag(wr_flag), .wr_mask(wr_mask)
  );

  irq_flag_bank #(.SRC_N(SRC_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_flag), .wr_data(bus_wdata[SRC_N-1:0]),
    .set_in(src_set), .clr_in(svc_clr), .flags(flag_q)
  );

  assign pend = flag_q & mask_q;

  irq_prio_pick #(.SRC_N(SRC_N), .IDX_W(IDX_W)) u_pick (
    .pend(pend), .grant(grant), .idx(win_idx), .any(win_any)
  );

  assign decide  = ime_q & ~busy_q & win_any;
  assign svc_clr = decide ? grant : '0;
  assign vec_d   = VEC_BASE + VEC_W'(vec_offset(VEC_STRIDE, 32'(win_idx)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_mask) mask_q <= bus_wdata[SRC_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ime_q <= 1'b0;
    else if (decide || di_strobe)    ime_q <= 1'b0;
    else if (ei_strobe)              ime_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (decide)  busy_q <= 1'b1;
    else if (svc_ack) busy_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_req <= 1'b0;
      svc_vec <= '0;
    end else begin
      svc_req <= decide;
      if (decide) svc_vec <= vec_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_FLAG: bus_rdata = DATA_W'(flag_q);
      SEL_MASK: bus_rdata = DATA_W'(mask_q);
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned SRC_N = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 'h0040,
  parameter int unsigned VEC_STRIDE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [SRC_N-1:0]  src_set,
  input logic              di_strobe,
  input logic              svc_ack,
  input logic              svc_req,
  input logic [VEC_W-1:0]  svc_vec,
  input logic [SRC_N-1:0]  flag_q,
  input logic [SRC_N-1:0]  svc_clr,
  input logic              ime_q,
  input logic              busy_q
);

  localparam logic [VEC_W-1:0] SPAN = VEC_W'(SRC_N * VEC_STRIDE);
  localparam logic [VEC_W-1:0] STEP = VEC_W'(VEC_STRIDE);

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata >> SRC_N) == '0);

  p_vec_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> (((svc_vec - VEC_BASE) % STEP) == '0 && (svc_vec - VEC_BASE) < SPAN));

  p_ime_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> !ime_q);

  p_one_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_clr));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set != '0) |=> ((flag_q & $past(src_set)) == $past(src_set)));

  p_di_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    di_strobe |=> !ime_q);

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |=> !svc_req);

  p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !svc_ack) |=> !svc_req);

endmodule

bind irq_ctrl irq_ctrl_chk #(
  .SRC_N(SRC_N), .DATA_W(DATA_W), .VEC_W(VEC_W),
  .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rdata(bus_rdata), .src_set(src_set),
  .di_strobe(di_strobe), .svc_ack(svc_ack), .svc_req(svc_req), .svc_vec(svc_vec),
  .flag_q(flag_q), .svc_clr(svc_clr), .ime_q(ime_q), .busy_q(busy_q)
);

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;

  localparam logic [15:0] A_MASK = 16'hFFFF;
  localparam logic [15:0] A_FLAG = 16'hFF0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [4:0]  src_set = 5'h0;
  logic        ei_strobe = 1'b0;
  logic        di_strobe = 1'b0;
  logic        svc_ack = 1'b0;
  logic        svc_req;
  logic [15:0] svc_vec;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_set(src_set),
    .ei_strobe(ei_strobe), .di_strobe(di_strobe), .svc_ack(svc_ack),
    .svc_req(svc_req), .svc_vec(svc_vec)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    check(req, 32'(bus_rdata), 32'(exp));
  endtask

  task automatic pulse_ei();
    ei_strobe = 1'b1; tick(); ei_strobe = 1'b0;
  endtask

  task automatic pulse_di();
    di_strobe = 1'b1; tick(); di_strobe = 1'b0;
  endtask

  task automatic do_ack();
    svc_ack = 1'b1; tick(); svc_ack = 1'b0;
  endtask

  function automatic int low_bit(input logic [4:0] v);
    for (int i = 4; i >= 0; i--) begin
      if (v[i]) low_bit = i;
    end
  endfunction

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R10 reset state
    check("R10 svc_req", 32'(svc_req), 0);
    read_chk("R10 flags", A_FLAG, 8'h00);
    read_chk("R10 mask", A_MASK, 8'h00);

    // R1 field width and unmapped reads
    bus_write(A_FLAG, 8'hFF);
    read_chk("R1 flag upper", A_FLAG, 8'h1F);
    bus_write(A_MASK, 8'hE3);
    read_chk("R1 mask upper", A_MASK, 8'h03);
    read_chk("R1 unmapped", 16'hFF00, 8'h00);
    tick(); tick();
    check("R3 no ime no req", 32'(svc_req), 0);

    // R9 direct load of flags
    bus_write(A_FLAG, 8'h0A);
    read_chk("R9 load", A_FLAG, 8'h0A);
    bus_write(A_FLAG, 8'h00);
    read_chk("R9 clear", A_FLAG, 8'h00);

    // R2 R4 R5 R3 exhaustive sweep of flags x mask
    for (int f = 0; f < 32; f++) begin
      for (int m = 0; m < 32; m++) begin
        logic [4:0] p;
        int n;
        pulse_di();
        bus_write(A_MASK, 8'(m));
        bus_write(A_FLAG, 8'(f));
        pulse_ei();
        tick();
        p = 5'(f) & 5'(m);
        if (p != 0) begin
          n = low_bit(p);
          check("R5 req", 32'(svc_req), 1);
          check("R2 vec", 32'(svc_vec), 32'h40 + 32'(8 * n));
          read_chk("R4 flags left", A_FLAG, 8'(5'(f) & ~(5'd1 << n)));
          tick();
          check("R8 pulse end", 32'(svc_req), 0);
          do_ack();
          tick(); tick();
          check("R4 ime dropped", 32'(svc_req), 0);
        end else begin
          check("R3 no pend", 32'(svc_req), 0);
          read_chk("R3 flags kept", A_FLAG, 8'(f));
        end
      end
    end

    // R6 each source set strobe, then served
    for (int n = 0; n < 5; n++) begin
      pulse_di();
      bus_write(A_MASK, 8'h1F);
      bus_write(A_FLAG, 8'h00);
      pulse_ei();
      src_set = 5'(1 << n);
      tick();
      src_set = 5'h0;
      tick();
      check("R6 set served", 32'(svc_req), 1);
      check("R6 set vec", 32'(svc_vec), 32'h40 + 32'(8 * n));
      do_ack();
    end

    // R6 set collides with service clear
    pulse_di();
    bus_write(A_MASK, 8'h01);
    bus_write(A_FLAG, 8'h01);
    pulse_ei();
    src_set = 5'h01;
    tick();
    src_set = 5'h0;
    check("R6 collide req", 32'(svc_req), 1);
    read_chk("R6 set wins", A_FLAG, 8'h01);
    do_ack();

    // R6 set collides with bus write of zero
    src_set = 5'h04; bus_write(A_FLAG, 8'h00); src_set = 5'h0;
    read_chk("R6 set beats write", A_FLAG, 8'h04);

    // R7 simultaneous enable and disable
    bus_write(A_FLAG, 8'h01);
    ei_strobe = 1'b1; di_strobe = 1'b1; tick();
    ei_strobe = 1'b0; di_strobe = 1'b0;
    tick(); tick();
    check("R7 di wins", 32'(svc_req), 0);
    pulse_ei();
    tick();
    check("R7 ei enables", 32'(svc_req), 1);
    do_ack();

    // R8 no decision until ack
    pulse_di();
    bus_write(A_MASK, 8'h1F);
    bus_write(A_FLAG, 8'h06);
    pulse_ei();
    tick();
    check("R8 first", 32'(svc_vec), 32'h48);
    pulse_ei();
    tick();
    check("R8 held a", 32'(svc_req), 0);
    tick();
    check("R8 held b", 32'(svc_req), 0);
    check("R8 vec holds", 32'(svc_vec), 32'h48);
    do_ack();
    tick();
    check("R8 after ack req", 32'(svc_req), 1);
    check("R8 after ack vec", 32'(svc_vec), 32'h50);
    do_ack();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule